// File: doc/BRIEF.md
# Block-Lock Write Protection Controller

This block sits in front of a 16K x 8 nonvolatile storage array. It decides, one request at a time, whether a write may reach the array. It also holds the protection control register, which is mapped at the top of a 16-bit address space (FFFFh). Each strobed write request carries an address and a data byte. The block answers one cycle later with exactly one pulse: grant or deny. When the register is the target and the write is allowed, the register is updated on the same edge.

Protection has three layers:
- **Software enable latch.** A volatile latch must be set before any nonvolatile change is accepted.
- **Block lock.** A two-bit field locks the top quarter, the top half, or all of the array. Writes that fall inside the locked region are refused in every case.
- **Pin-gated lock of the register.** A hardware-protect enable bit, combined with a high level on the protect pin, freezes the lock field and the enable bit itself.

The latch clears on reset. The lock field and the hardware-protect enable keep their values across reset, because they model nonvolatile cells. The surrounding storage, bus and write timing logic uses the grant pulse to start a real write.

Top module: `wpc_top`

## Requirements
- R1: While reset is active, and until the first request after it, grant and deny are low and register bit 1 (the enable latch) reads 0.
- R2: A write to address FFFFh always loads data bit 1 into the enable latch. The register reads back as {bit7 = hardware-protect enable, bits 4:3 = lock field, bit 1 = enable latch}, and bits 6, 5, 2 and 0 read 0.
- R3: A register write changes bits 7 and 4:3 only if the enable latch was already 1 before that write. Such a write is answered with grant; otherwise it is answered with deny and those bits are unchanged.
- R4: An array write (address below 4000h) outside the locked region is granted only when the enable latch is 1 and is denied otherwise. An array write never changes the register.
- R5: Lock field encodings: 00 locks nothing, 01 locks 3000h-3FFFh, 10 locks 2000h-3FFFh, 11 locks 0000h-3FFFh. Array writes inside the locked region are denied whatever the enable latch holds.
- R6: When the protect pin is high and bit 7 is 1, register writes are denied and bits 7 and 4:3 keep their values, while bit 1 still follows data bit 1. With the pin low, those bits are writable again under R3.
- R7: A write to any address from 4000h to FFFEh is denied.
- R8: Every strobe produces exactly one of grant or deny, one clock cycle later and lasting one cycle. No pulse appears without a strobe.
- R9: Reset clears the enable latch and leaves bits 7 and 4:3 at their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_req | input | 1 | Write strobe, one request per high cycle |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| wp_pin | input | 1 | Hardware write-protect level |
| grant | output | 1 | One-cycle pulse: request accepted |
| deny | output | 1 | One-cycle pulse: request refused |
| ctrl_rd | output | 8 | Current protection register contents |

## Verification
Directed sequences place writes on both sides of each lock boundary (1FFFh/2000h, 2FFFh/3000h, 3FFFh/4000h). Each lock level is visited with the enable latch both set and clear, which separates a wrong range comparison from a missing latch gate. Register writes are tried with the protect pin high and low and with the enable bit set and clear, which shows whether the pin lock and the latch rule act independently. A mid-run reset shows that only the latch is volatile. Random requests are then drawn from $urandom with a fixed seed, mixing register, array and unmapped addresses with random data and pin levels, so that long chains of state changes are compared against a bench model.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int WEL_BIT  = 1;
  localparam int LOCK_LO  = 3;
  localparam int LOCK_HI  = 4;
  localparam int HWEN_BIT = 7;

  typedef enum logic [1:0] {
    LOCK_NONE = 2'b00,
    LOCK_QTR  = 2'b01,
    LOCK_HALF = 2'b10,
    LOCK_ALL  = 2'b11
  } lock_e;

  typedef struct packed {
    logic  hwen;
    lock_e lock;
    logic  wel;
  } prot_s;
endpackage

// File: rtl/wpc_lock_range.sv
module wpc_lock_range #(
  parameter int ADDR_W      = 16,
  parameter int ARRAY_DEPTH = 16384
) (
  input  logic [ADDR_W-1:0] addr,
  input  wpc_pkg::lock_e    lock,
  output logic              in_array,
  output logic              in_locked
);
  import wpc_pkg::*;

  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(ARRAY_DEPTH);
  localparam logic [ADDR_W:0] QTR_V   = (ADDR_W+1)'(ARRAY_DEPTH - ARRAY_DEPTH/4);
  localparam logic [ADDR_W:0] HALF_V  = (ADDR_W+1)'(ARRAY_DEPTH/2);

  logic [ADDR_W:0] a_ext;
  logic            hit;

  assign a_ext    = {1'b0, addr};
  assign in_array = (a_ext < DEPTH_V);

  always_comb begin
    unique case (lock)
      LOCK_NONE: hit = 1'b0;
      LOCK_QTR:  hit = (a_ext >= QTR_V);
      LOCK_HALF: hit = (a_ext >= HALF_V);
      default:   hit = 1'b1;
    endcase
  end

  assign in_locked = in_array & hit;
endmodule

// File: rtl/wpc_decide.sv
module wpc_decide #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int ARRAY_DEPTH = 16384
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              wp_pin,
  input  wpc_pkg::prot_s    cur,
  output logic              grant_d,
  output logic              deny_d,
  output logic              wel_we,
  output logic              nv_we,
  output wpc_pkg::prot_s    nxt
);
  import wpc_pkg::*;

  localparam logic [ADDR_W-1:0] REG_ADDR = '1;

  logic is_reg, in_array, in_locked, hw_lock, nv_ok, ok;

  wpc_lock_range #(.ADDR_W(ADDR_W), .ARRAY_DEPTH(ARRAY_DEPTH)) u_range (
    .addr      (addr),
    .lock      (cur.lock),
    .in_array  (in_array),
    .in_locked (in_locked)
  );

  assign is_reg  = (addr == REG_ADDR);
  assign hw_lock = wp_pin & cur.hwen;
  assign nv_ok   = cur.wel & ~hw_lock;

  always_comb begin
    nxt      = cur;
    nxt.wel  = data[WEL_BIT];
    nxt.lock = lock_e'(data[LOCK_HI:LOCK_LO]);
    nxt.hwen = data[HWEN_BIT];
    if (is_reg)        ok = nv_ok;
    else if (in_array) ok = cur.wel & ~in_locked;
    else               ok = 1'b0;
  end

  assign wel_we  = req & is_reg;
  assign nv_we   = req & is_reg & nv_ok;
  assign grant_d = req & ok;
  assign deny_d  = req & ~ok;
endmodule

// File: rtl/wpc_prot_regs.sv
module wpc_prot_regs (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wel_we,
  input  logic           nv_we,
  input  wpc_pkg::prot_s nxt,
  output wpc_pkg::prot_s q
);
  import wpc_pkg::*;

  logic  wel_q;
  lock_e lock_q;
  logic  hwen_q;

  // Volatile latch: cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel_q <= 1'b0;
    else if (wel_we) wel_q <= nxt.wel;
  end

  // Nonvolatile cells: not touched by reset
  always_ff @(posedge clk) begin
    if (nv_we) begin
      lock_q <= nxt.lock;
      hwen_q <= nxt.hwen;
    end
  end

  assign q = '{hwen: hwen_q, lock: lock_q, wel: wel_q};
endmodule

// File: rtl/wpc_top.sv
module wpc_top #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int ARRAY_DEPTH = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wp_pin,
  output logic              grant,
  output logic              deny,
  output logic [DATA_W-1:0] ctrl_rd
);
  import wpc_pkg::*;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  prot_s      cur, nxt;
  logic       grant_d, deny_d, wel_we, nv_we;
  logic       grant_q, deny_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  wpc_decide #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARRAY_DEPTH(ARRAY_DEPTH)) u_dec (
    .req     (wr_req),
    .addr    (wr_addr),
    .data    (wr_data),
    .wp_pin  (wp_pin),
    .cur     (cur),
    .grant_d (grant_d),
    .deny_d  (deny_d),
    .wel_we  (wel_we),
    .nv_we   (nv_we),
    .nxt     (nxt)
  );

  wpc_prot_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wel_we (wel_we),
    .nv_we  (nv_we),
    .nxt    (nxt),
    .q      (cur)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= grant_d;
      deny_q  <= deny_d;
    end
  end

  assign grant = grant_q;
  assign deny  = deny_q;

  always_comb begin
    ctrl_rd                  = '0;
    ctrl_rd[WEL_BIT]         = cur.wel;
    ctrl_rd[LOCK_HI:LOCK_LO] = cur.lock;
    ctrl_rd[HWEN_BIT]        = cur.hwen;
  end
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int ARRAY_DEPTH = 16384
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wp_pin,
  input logic              grant,
  input logic              deny,
  input logic [DATA_W-1:0] ctrl_rd
);
  logic is_reg, is_arr, is_gap, locked;
  int   field, thresh;

  always_comb begin
    is_reg = &wr_addr;
    is_arr = (int'(wr_addr) < ARRAY_DEPTH);
    is_gap = !is_reg && !is_arr;
    field  = int'(ctrl_rd[4:3]);
    thresh = (field == 3) ? 0 : ARRAY_DEPTH - field * (ARRAY_DEPTH / 4);
    locked = is_arr && (int'(wr_addr) >= thresh);
  end

  // R8
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_req |=> (grant ^ deny));
  // R8
  no_idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_req |=> (!grant && !deny));
  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_req && is_reg) |=> (ctrl_rd[1] == $past(wr_data[1])));
  // R3
  nv_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_req && is_reg && !ctrl_rd[1]) |=> ($stable({ctrl_rd[7], ctrl_rd[4:3]}) && deny));
  // R4
  array_latch_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_req && is_arr && !ctrl_rd[1]) |=> deny);
  // R5
  locked_deny_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_req && locked) |=> deny);
  // R6
  pin_lock_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_req && is_reg && wp_pin && ctrl_rd[7]) |=> ($stable({ctrl_rd[7], ctrl_rd[4:3]}) && deny));
  // R7
  gap_deny_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_req && is_gap) |=> deny);
endmodule

bind wpc_top wpc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARRAY_DEPTH(ARRAY_DEPTH)) u_chk (
  .clk     (clk),
  .rst_ni  (rst_sync_n),
  .wr_req  (wr_req),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .wp_pin  (wp_pin),
  .grant   (grant),
  .deny    (deny),
  .ctrl_rd (ctrl_rd)
);

// File: tb/sim_wpc_top.sv
`timescale 1ns/1ps
module sim_wpc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_req = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wp_pin = 1'b0;
  logic        grant, deny;
  logic [7:0]  ctrl_rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the register
  bit       m_wel = 0;
  bit [1:0] m_lock = 0;
  bit       m_hwen = 0;
  bit       m_known = 0;

  always #10 clk = ~clk;

  wpc_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wp_pin(wp_pin), .grant(grant), .deny(deny),
    .ctrl_rd(ctrl_rd)
  );

  function automatic bit in_lock(input bit [1:0] f, input bit [15:0] a);
    case (f)
      2'd0: return 0;
      2'd1: return (a >= 16'h3000);
      2'd2: return (a >= 16'h2000);
      default: return 1;
    endcase
  endfunction

  function automatic bit [7:0] model_reg();
    return {m_hwen, 2'b00, m_lock, 1'b0, m_wel, 1'b0};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "grant in reset", grant, 0);
    check("R1", "deny in reset", deny, 0);
    check("R1", "latch in reset", ctrl_rd[1], 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_wel = 0;
  endtask

  task automatic do_write(input bit [15:0] a, input bit [7:0] d, input string req);
    bit ok;
    bit nv_ok;
    if (a == 16'hFFFF) begin
      nv_ok = m_wel && !(wp_pin && m_hwen);
      ok = nv_ok;
      m_wel = d[1];
      if (nv_ok) begin
        m_lock = d[4:3];
        m_hwen = d[7];
      end
    end else if (a < 16'h4000) begin
      ok = m_wel && !in_lock(m_lock, a);
    end else begin
      ok = 0;
    end
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0;
    check(req, $sformatf("grant @%h", a), grant, ok);
    check(req, $sformatf("deny @%h", a), deny, !ok);
    if (m_known) check(req, "register", ctrl_rd, model_reg());
    else         check(req, "latch", ctrl_rd[1], m_wel);
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R8", "grant idle", grant, 0);
    check("R8", "deny idle", deny, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    do_reset();
    idle_check();
    // R3: first register write with latch clear is refused, latch loads (R2)
    do_write(16'hFFFF, 8'h02, "R3");
    // R2: pin low, latch set: NV loads, bench model now exact
    do_write(16'hFFFF, 8'h02, "R2");
    m_known = 1;
    check("R2", "register", ctrl_rd, 8'h02);
    idle_check();
    // R2 unused bits stay zero
    do_write(16'hFFFF, 8'h67, "R2");
    do_write(16'hFFFF, 8'h02, "R2");
    // R4: no lock, latch set
    do_write(16'h0000, 8'hAA, "R4");
    do_write(16'h3FFF, 8'h55, "R4");
    // R7: unmapped
    do_write(16'h4000, 8'h11, "R7");
    do_write(16'hFFFE, 8'h11, "R7");
    // R5 quarter
    do_write(16'hFFFF, 8'h0A, "R5");
    do_write(16'h2FFF, 8'h00, "R5");
    do_write(16'h3000, 8'h00, "R5");
    // R5 half
    do_write(16'hFFFF, 8'h12, "R5");
    do_write(16'h1FFF, 8'h00, "R5");
    do_write(16'h2000, 8'h00, "R5");
    // R5 all
    do_write(16'hFFFF, 8'h1A, "R5");
    do_write(16'h0000, 8'h00, "R5");
    // R4: latch clear denies unlocked array write
    do_write(16'hFFFF, 8'h18, "R3");
    do_write(16'hFFFF, 8'h02, "R3");
    do_write(16'hFFFF, 8'h02, "R3");
    do_write(16'hFFFF, 8'h00, "R4");
    do_write(16'h0100, 8'h00, "R4");
    // R6: arm hardware lock with quarter lock, then pin high
    do_write(16'hFFFF, 8'h02, "R6");
    do_write(16'hFFFF, 8'h8A, "R6");
    wp_pin = 1'b1;
    do_write(16'hFFFF, 8'h02, "R6");
    do_write(16'hFFFF, 8'h00, "R6");
    do_write(16'hFFFF, 8'h02, "R6");
    do_write(16'h3000, 8'h00, "R6");
    wp_pin = 1'b0;
    do_write(16'hFFFF, 8'h12, "R6");
    // R9: mid-run reset keeps NV bits, clears latch
    do_reset();
    check("R9", "register after reset", ctrl_rd, model_reg());
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      bit [15:0] a;
      bit [7:0]  d;
      int sel;
      sel = $urandom_range(0, 9);
      d = 8'($urandom);
      if (sel < 4)      a = 16'hFFFF;
      else if (sel < 8) a = 16'($urandom_range(0, 16'h3FFF));
      else              a = 16'($urandom_range(16'h4000, 16'hFFFE));
      if (sel < 4 && $urandom_range(0, 3) != 0) d[1] = 1'b1;
      wp_pin = ($urandom_range(0, 3) == 0);
      do_write(a, d, "R8");
      if ($urandom_range(0, 15) == 0) idle_check();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule